// File: doc/BRIEF.md
# Adaptive Security Primitive Controller

This block is the lifecycle controller for a reconfigurable cryptographic accelerator. After reset it sits in an initialisation state. There it samples the battery level and the communication channel quality on every cycle and turns them into a mask of the configurations the system can afford. A host processor picks a configuration index. If that index is in the mask, the controller selects it, issues a one-cycle load strobe and waits for the datapath to report that loading has finished. It then raises ready and run enable.

While the primitive runs, the host may pick a different configuration for performance reasons, which sends the controller back to configuration. When computation ends, the primitive either idles and stays loaded, or stops and is treated as removed. A restart from the stopped state goes back to initialisation and sampling starts again.

A separate path is always active and watches a request line from the system security controller. A request from that controller wins over every other input in every state. It forces a reload of the configuration that the security controller names and stalls the primitive's I/O for one extra cycle once loading is complete. Bitstream transfer, the cipher itself and the attack monitors are outside the block and appear only as handshake inputs.

Top module: `sec_prim_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the controller in initialisation with `cfg_sel`, `feasible_mask`, `cfg_load`, `run_en`, `ready`, `idle` and `stopped` all zero.
- R2: In initialisation, `feasible_mask` takes a new value at each clock edge from the levels present before that edge. Call a level good when it is at least its threshold (default 64). With both levels good, all bits are set. With exactly one good, only the bits with index below NCFG/2 are set. With neither good, only bit 0 is set. In every other state the mask holds its value.
- R3: In initialisation, `param_valid` with `param_cfg` naming a set bit of `feasible_mask` moves the controller to configuration, with `cfg_sel` equal to `param_cfg` and `cfg_load` high for exactly one cycle. If the named bit is clear, the request is ignored and the controller stays in initialisation.
- R4: In configuration, `run_en` and `ready` are low. `load_done` moves the controller to run, where `ready` is high and `run_en` is high unless R10 applies.
- R5: In run or idle, a feasible `param_valid` is a performance reconfiguration: the next cycle is in configuration with the new `cfg_sel` and a load strobe. In run it wins over `comp_done`.
- R6: In run, `comp_done` with `comp_remove` low leads to idle (`idle` and `ready` high, `run_en` low). With `comp_remove` high it leads to stop (`stopped` high, `ready` low). In idle, `resume` returns to run.
- R7: In stop, only `restart` (back to initialisation, where the mask is sampled again) and `sec_req` have any effect.
- R8: `sec_req` in any state moves the controller to configuration at the next edge, with `cfg_sel` equal to `sec_cfg` even when that index is not in the mask, and a load strobe.
- R9: `sec_req` wins over `param_valid`, `comp_done` and `load_done` that arrive in the same cycle.
- R10: After a configuration entered through `sec_req`, `run_en` stays low during the first cycle in run and rises in the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| batt_level | input | LVL_W | Battery level, sampled in initialisation |
| chan_quality | input | LVL_W | Channel quality, sampled in initialisation |
| param_valid | input | 1 | Host presents a configuration choice |
| param_cfg | input | CIDX_W | Host configuration index |
| load_done | input | 1 | Datapath finished loading |
| comp_done | input | 1 | Computation finished |
| comp_remove | input | 1 | With comp_done: 1 stop and remove, 0 idle |
| resume | input | 1 | Leave idle for run |
| restart | input | 1 | Leave stop for initialisation |
| sec_req | input | 1 | Security controller forces reconfiguration |
| sec_cfg | input | CIDX_W | Index demanded by the security controller |
| feasible_mask | output | NCFG | Configurations the system can afford |
| cfg_sel | output | CIDX_W | Selected configuration index |
| cfg_load | output | 1 | One-cycle load strobe |
| run_en | output | 1 | Primitive I/O enabled |
| ready | output | 1 | Primitive loaded (run or idle) |
| idle | output | 1 | Primitive idle and still loaded |
| stopped | output | 1 | Primitive stopped and removed |

## Verification
Each output is registered or decoded from a register, so every result is due exactly one rising edge after the inputs that cause it. The one exception is the R10 stall, which covers the first run cycle after a security load and releases on the edge after it. The bench changes inputs on the falling edge, advances its own model at the rising edge from the same inputs, and compares all outputs at the next falling edge. Directed steps also check hard-coded values one edge after each stimulus. The R2 mask lags its levels by one edge, so the bench holds new levels for one cycle before it makes any request that depends on them.

// File: rtl/spc_pkg.sv
// Shared state type for the security primitive controller.
package spc_pkg;
    typedef enum logic [2:0] {
        ST_INIT   = 3'd0,
        ST_CONFIG = 3'd1,
        ST_RUN    = 3'd2,
        ST_IDLE   = 3'd3,
        ST_STOP   = 3'd4
    } spc_state_e;
endpackage

// File: rtl/spc_feasibility.sv
// Feasibility sampler: turns battery and channel levels into a mask of
// affordable configurations. Assumes that a low index means a cheaper
// configuration. The mask updates only while sample_en is high.
module spc_feasibility #(
    parameter int NCFG    = 8,
    parameter int LVL_W   = 8,
    parameter int BATT_TH = 64,
    parameter int CHAN_TH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic [LVL_W-1:0] batt_level,
    input  logic [LVL_W-1:0] chan_quality,
    output logic [NCFG-1:0]  mask
);
    localparam int HALF = NCFG / 2;

    logic            batt_ok;
    logic            chan_ok;
    logic            both_ok;
    logic            one_ok;
    logic [NCFG-1:0] mask_d;

    // Purpose: grade each level against its threshold.
    always_comb begin
        batt_ok = (batt_level >= LVL_W'(BATT_TH));
        chan_ok = (chan_quality >= LVL_W'(CHAN_TH));
        both_ok = batt_ok && chan_ok;
        one_ok  = batt_ok ^ chan_ok;
    end

    // One mask bit per configuration, chosen by its class of cost.
    for (genvar i = 0; i < NCFG; i++) begin : g_bit
        if (i == 0) begin : g_base
            assign mask_d[i] = 1'b1;
        end else if (i < HALF) begin : g_low
            assign mask_d[i] = both_ok || one_ok;
        end else begin : g_high
            assign mask_d[i] = both_ok;
        end
    end

    // Purpose: register the mask while sampling is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask <= '0;
        else if (sample_en) mask <= mask_d;
    end
endmodule

// File: rtl/spc_next_state.sv
// Next-state logic. The security path is evaluated ahead of every
// state-specific rule, so it pre-empts all of them. Purely combinational.
module spc_next_state
    import spc_pkg::*;
#(
    parameter int NCFG   = 8,
    parameter int CIDX_W = 3
) (
    input  spc_state_e        state,
    input  logic [NCFG-1:0]   mask,
    input  logic              sec_req,
    input  logic              param_valid,
    input  logic [CIDX_W-1:0] param_cfg,
    input  logic              load_done,
    input  logic              comp_done,
    input  logic              comp_remove,
    input  logic              resume,
    input  logic              restart,
    output spc_state_e        nxt,
    output logic              take_host,
    output logic              take_sec
);
    logic host_ok;

    // Purpose: accept a host choice only when it is in the mask.
    always_comb begin
        host_ok = param_valid && (int'(param_cfg) < NCFG) && mask[param_cfg];
    end

    // Purpose: choose the next state; security first, then per state.
    always_comb begin
        nxt       = state;
        take_host = 1'b0;
        take_sec  = 1'b0;
        if (sec_req) begin
            nxt      = ST_CONFIG;
            take_sec = 1'b1;
        end else begin
            case (state)
                ST_INIT: if (host_ok) begin
                    nxt       = ST_CONFIG;
                    take_host = 1'b1;
                end
                ST_CONFIG: if (load_done) nxt = ST_RUN;
                ST_RUN: begin
                    if (host_ok) begin
                        nxt       = ST_CONFIG;
                        take_host = 1'b1;
                    end else if (comp_done) begin
                        nxt = comp_remove ? ST_STOP : ST_IDLE;
                    end
                end
                ST_IDLE: begin
                    if (host_ok) begin
                        nxt       = ST_CONFIG;
                        take_host = 1'b1;
                    end else if (resume) begin
                        nxt = ST_RUN;
                    end
                end
                ST_STOP: if (restart) nxt = ST_INIT;
                default: nxt = ST_INIT;
            endcase
        end
    end
endmodule

// File: rtl/spc_out_decode.sv
// Output decoder: derives the status flags from the state and the stall
// flag. Assumes that stall is set only around a security-forced load.
module spc_out_decode
    import spc_pkg::*;
(
    input  spc_state_e state,
    input  logic       stall,
    output logic       run_en,
    output logic       ready,
    output logic       idle,
    output logic       stopped
);
    // Purpose: Moore decode of the lifecycle flags.
    always_comb begin
        run_en  = (state == ST_RUN) && !stall;
        ready   = (state == ST_RUN) || (state == ST_IDLE);
        idle    = (state == ST_IDLE);
        stopped = (state == ST_STOP);
    end
endmodule

// File: rtl/sec_prim_ctrl.sv
// Adaptive security primitive controller (top). Sequences initialisation,
// configuration, run, idle and stop. A security request forces a reload
// from any state. Assumes that all inputs are synchronous to clk.
module sec_prim_ctrl
    import spc_pkg::*;
#(
    parameter int NCFG    = 8,
    parameter int LVL_W   = 8,
    parameter int BATT_TH = 64,
    parameter int CHAN_TH = 64,
    localparam int CIDX_W = (NCFG > 1) ? $clog2(NCFG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  batt_level,
    input  logic [LVL_W-1:0]  chan_quality,
    input  logic              param_valid,
    input  logic [CIDX_W-1:0] param_cfg,
    input  logic              load_done,
    input  logic              comp_done,
    input  logic              comp_remove,
    input  logic              resume,
    input  logic              restart,
    input  logic              sec_req,
    input  logic [CIDX_W-1:0] sec_cfg,
    output logic [NCFG-1:0]   feasible_mask,
    output logic [CIDX_W-1:0] cfg_sel,
    output logic              cfg_load,
    output logic              run_en,
    output logic              ready,
    output logic              idle,
    output logic              stopped
);
    spc_state_e state_q;
    spc_state_e state_d;
    logic       take_host;
    logic       take_sec;
    logic       stall_q;

    spc_feasibility #(
        .NCFG(NCFG), .LVL_W(LVL_W), .BATT_TH(BATT_TH), .CHAN_TH(CHAN_TH)
    ) u_feas (
        .clk(clk), .rst_n(rst_n),
        .sample_en(state_q == ST_INIT),
        .batt_level(batt_level), .chan_quality(chan_quality),
        .mask(feasible_mask)
    );

    spc_next_state #(.NCFG(NCFG), .CIDX_W(CIDX_W)) u_nxt (
        .state(state_q), .mask(feasible_mask),
        .sec_req(sec_req), .param_valid(param_valid), .param_cfg(param_cfg),
        .load_done(load_done), .comp_done(comp_done),
        .comp_remove(comp_remove), .resume(resume), .restart(restart),
        .nxt(state_d), .take_host(take_host), .take_sec(take_sec)
    );

    spc_out_decode u_dec (
        .state(state_q), .stall(stall_q),
        .run_en(run_en), .ready(ready), .idle(idle), .stopped(stopped)
    );

    // Purpose: state, selected index and load strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_INIT;
            cfg_sel  <= '0;
            cfg_load <= 1'b0;
        end else begin
            state_q  <= state_d;
            cfg_load <= take_sec || take_host;
            if (take_sec)       cfg_sel <= sec_cfg;
            else if (take_host) cfg_sel <= param_cfg;
        end
    end

    // Purpose: hold I/O stalled for the first run cycle after a security load.
    always_ff @(posedge clk) begin
        if (!rst_n)                 stall_q <= 1'b0;
        else if (take_sec)          stall_q <= 1'b1;
        else if (state_q == ST_RUN) stall_q <= 1'b0;
    end

    a_r8_sec_forces_config: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(sec_req) |->
            (state_q == ST_CONFIG) && cfg_load && (cfg_sel == $past(sec_cfg)));

    a_r4_run_implies_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |-> ready && !cfg_load);

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (!cfg_load || $past(sec_req) || $past(param_valid)));

    a_r6_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({run_en, idle, stopped, cfg_load}));

    a_r7_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(stopped) && !$past(restart) && !$past(sec_req)
            |-> stopped);

    a_r10_stall_after_sec: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(state_q == ST_CONFIG) && (state_q == ST_RUN)
            && $past(stall_q) |-> !run_en);

    a_r2_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(state_q) != ST_INIT) |-> $stable(feasible_mask));
endmodule

// File: tb/sec_prim_ctrl_test.sv
// Bench: directed corner cases followed by seeded random stimulus, checked
// against a behavioural model written from the requirements.
module sec_prim_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCFG = 8;
    localparam int CW   = 3;
    localparam int M_INIT = 0, M_CFG = 1, M_RUN = 2, M_IDLE = 3, M_STOP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] batt_level = '0, chan_quality = '0;
    logic param_valid = 1'b0, load_done = 1'b0, comp_done = 1'b0;
    logic comp_remove = 1'b0, resume = 1'b0, restart = 1'b0, sec_req = 1'b0;
    logic [CW-1:0] param_cfg = '0, sec_cfg = '0;
    logic [NCFG-1:0] feasible_mask;
    logic [CW-1:0] cfg_sel;
    logic cfg_load, run_en, ready, idle, stopped;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int m_st = M_INIT;
    logic [NCFG-1:0] m_mask = '0;
    logic [CW-1:0] m_sel = '0;
    bit m_load = 1'b0, m_stall = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_prim_ctrl uut (
        .clk(clk), .rst_n(rst_n), .batt_level(batt_level),
        .chan_quality(chan_quality), .param_valid(param_valid),
        .param_cfg(param_cfg), .load_done(load_done), .comp_done(comp_done),
        .comp_remove(comp_remove), .resume(resume), .restart(restart),
        .sec_req(sec_req), .sec_cfg(sec_cfg), .feasible_mask(feasible_mask),
        .cfg_sel(cfg_sel), .cfg_load(cfg_load), .run_en(run_en),
        .ready(ready), .idle(idle), .stopped(stopped)
    );

    function automatic logic [NCFG-1:0] exp_mask(logic [7:0] b, logic [7:0] c);
        int good;
        good = int'(b >= 8'd64) + int'(c >= 8'd64);
        if (good == 2) return '1;
        if (good == 1) return NCFG'((1 << (NCFG/2)) - 1);
        return NCFG'(1);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model by one edge, using the inputs that are present now.
    task automatic model_step();
        bit ok;
        int cur;
        cur = m_st;
        if (!rst_n) begin
            m_st = M_INIT; m_mask = '0; m_sel = '0; m_load = 0; m_stall = 0;
            return;
        end
        ok = param_valid && m_mask[param_cfg];
        m_load = 0;
        if (sec_req) begin
            m_st = M_CFG; m_sel = sec_cfg; m_load = 1;
        end else begin
            case (cur)
                M_INIT: if (ok) begin m_st = M_CFG; m_sel = param_cfg; m_load = 1; end
                M_CFG:  if (load_done) m_st = M_RUN;
                M_RUN: begin
                    if (ok) begin m_st = M_CFG; m_sel = param_cfg; m_load = 1; end
                    else if (comp_done) m_st = comp_remove ? M_STOP : M_IDLE;
                end
                M_IDLE: begin
                    if (ok) begin m_st = M_CFG; m_sel = param_cfg; m_load = 1; end
                    else if (resume) m_st = M_RUN;
                end
                default: if (restart) m_st = M_INIT;
            endcase
        end
        if (sec_req) m_stall = 1;
        else if (cur == M_RUN) m_stall = 0;
        if (cur == M_INIT) m_mask = exp_mask(batt_level, chan_quality);
    endtask

    task automatic cmp_model();
        chk("R2 mask", 32'(feasible_mask), 32'(m_mask));
        chk("R8 cfg_sel", 32'(cfg_sel), 32'(m_sel));
        chk("R3 cfg_load", 32'(cfg_load), 32'(m_load));
        chk("R10 run_en", 32'(run_en), 32'((m_st == M_RUN) && !m_stall));
        chk("R4 ready", 32'(ready), 32'((m_st == M_RUN) || (m_st == M_IDLE)));
        chk("R6 idle", 32'(idle), 32'(m_st == M_IDLE));
        chk("R6 stopped", 32'(stopped), 32'(m_st == M_STOP));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        cmp_model();
    endtask

    task automatic clear_in();
        param_valid = 0; load_done = 0; comp_done = 0; comp_remove = 0;
        resume = 0; restart = 0; sec_req = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EC1);
        @(negedge clk);
        rst_n = 0; sec_req = 1; param_valid = 1;
        tick(); tick();
        // R1: reset state with inputs active
        chk("R1 cfg_sel", 32'(cfg_sel), 0);
        chk("R1 mask", 32'(feasible_mask), 0);
        chk("R1 flags", 32'({cfg_load, run_en, ready, idle, stopped}), 0);
        rst_n = 1; clear_in();
        batt_level = 8'd200; chan_quality = 8'd90;
        tick();
        chk("R2 both good", 32'(feasible_mask), 32'hFF);
        param_valid = 1; param_cfg = 3'd6;
        tick();
        chk("R3 accept", 32'({cfg_load, cfg_sel}), 32'({1'b1, 3'd6}));
        clear_in();
        tick();
        chk("R3 one-cycle strobe", 32'(cfg_load), 0);
        chk("R4 no run in config", 32'({run_en, ready}), 0);
        load_done = 1;
        tick();
        chk("R4 run", 32'({run_en, ready}), 32'b11);
        clear_in(); param_valid = 1; param_cfg = 3'd2; comp_done = 1;
        tick();
        chk("R5 perf reconfig", 32'({cfg_load, cfg_sel, ready}), 32'({1'b1, 3'd2, 1'b0}));
        clear_in(); load_done = 1;
        tick();
        clear_in(); comp_done = 1;
        tick();
        chk("R6 idle", 32'({idle, ready, run_en}), 32'b110);
        clear_in(); resume = 1;
        tick();
        chk("R6 resume", 32'(run_en), 1);
        clear_in(); comp_done = 1; comp_remove = 1; sec_req = 1; sec_cfg = 3'd5;
        param_valid = 1; param_cfg = 3'd1;
        tick();
        chk("R9 sec wins", 32'({cfg_load, cfg_sel, stopped}), 32'({1'b1, 3'd5, 1'b0}));
        clear_in(); load_done = 1;
        tick();
        chk("R10 stall first run cycle", 32'({run_en, ready}), 32'b01);
        clear_in();
        tick();
        chk("R10 release", 32'(run_en), 1);
        comp_done = 1; comp_remove = 1;
        tick();
        chk("R6 stop", 32'({stopped, ready}), 32'b10);
        clear_in(); param_valid = 1; param_cfg = 3'd0; resume = 1; load_done = 1;
        tick();
        chk("R7 stop ignores", 32'({stopped, cfg_load}), 32'b10);
        clear_in(); restart = 1; batt_level = 8'd10; chan_quality = 8'd100;
        tick();
        chk("R7 back to init", 32'({stopped, ready, cfg_load}), 0);
        clear_in();
        tick();
        chk("R2 one good", 32'(feasible_mask), 32'h0F);
        param_valid = 1; param_cfg = 3'd6;
        tick();
        chk("R3 reject", 32'(cfg_load), 0);
        clear_in(); chan_quality = 8'd5;
        tick();
        chk("R2 none good", 32'(feasible_mask), 32'h01);
        batt_level = 8'd255; chan_quality = 8'd255;
        sec_req = 1; sec_cfg = 3'd7;
        tick();
        chk("R8 infeasible forced", 32'({cfg_load, cfg_sel}), 32'({1'b1, 3'd7}));
        clear_in(); batt_level = 8'd0;
        tick();
        chk("R2 held outside init", 32'(feasible_mask), 32'hFF);
        for (int n = 0; n < 4000; n++) begin
            clear_in();
            sec_req     = ($urandom % 25) == 0;
            sec_cfg     = CW'($urandom);
            param_valid = ($urandom % 6) == 0;
            param_cfg   = CW'($urandom);
            load_done   = ($urandom % 3) == 0;
            comp_done   = ($urandom % 6) == 0;
            comp_remove = $urandom % 2;
            resume      = ($urandom % 4) == 0;
            restart     = ($urandom % 4) == 0;
            batt_level  = 8'($urandom);
            chan_quality = 8'($urandom);
            rst_n       = ($urandom % 500) != 0;
            tick();
        end
        finish_run();
    end
endmodule